// File: doc/BRIEF.md
# Page Hamming ECC generator

This block watches the byte stream of a flash page transfer and builds a 24-bit single-error-correcting Hamming code for every 512-byte chunk of that page. The caller picks how many chunks a page holds through a two-bit size setting. The page is closed by a last-beat marker that travels with the final byte. After each chunk closes, its code is kept in a result slot together with a valid flag. A small read port lets the surrounding controller fetch any slot as a 32-bit word.

Each byte is registered once before it is folded into the running parity. For this reason the code of the final chunk is complete one clock after the last beat is accepted, and the block raises a busy flag for that clock. Valid flags are cleared when a new page begins, and they come back one by one as chunks close. Software or a spare-area writer can therefore tell fresh codes from codes that belong to an earlier page.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, busy is 0 and every result slot reads as all-zero (code 0, not valid).
- R2: For a chunk, let a byte at chunk offset b and bit i have the 12-bit address a = b*8 + i. Code bit k (k = 0..11) is the XOR of all data bits whose address has bit k set. Code bit 12+k is the XOR of all data bits whose address has bit k clear.
- R3: The size setting, sampled with the first beat of a page, gives the number of chunks: 3 means four, 2 means two, and 1 or 0 means one. Chunk n covers page bytes n*512 to n*512+511 and is read at rd_sel = n.
- R4: A result word carries the code in bits [23:0] and the valid flag in bit 30. Bits 31 and [29:24] read as 0.
- R5: busy is 1 in exactly the cycle after the beat flagged last is accepted, provided no further beat follows. When busy returns to 0, the final chunk's code and valid flag are readable.
- R6: All valid flags clear one cycle after the first beat of a new page is accepted. Each flag sets one cycle after its chunk's closing beat is accepted.
- R7: A last beat that arrives before a chunk's 512th byte closes that partial chunk with the bytes received so far. Later slots of the page stay not valid, and the next page starts again at chunk 0, offset 0.
- R8: Changes to the size setting after the first beat of a page do not affect that page.
- R9: Cycles with beat_valid low change no state, even when beat_last or beat_data toggle.
- R10: Bytes that follow the final configured chunk of a page start a fresh code in slot 0, and that code replaces the earlier value of slot 0 when the page closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page_size | input | 2 | Chunks per page: 3 gives four, 2 gives two, else one |
| beat_valid | input | 1 | A data byte is present this cycle |
| beat_data | input | 8 | Page data byte |
| beat_last | input | 1 | This byte ends the page |
| rd_sel | input | 2 | Result slot to read |
| rd_word | output | 32 | Selected slot: valid in bit 30, code in [23:0] |
| busy | output | 1 | Final code still being computed |

## Verification
If the running accumulator were left uncleared at a chunk boundary, or a byte went into the wrong offset, the code read in the same cycle that busy falls would differ from the independently computed code. This holds for every affected slot, so the error shows within one clock of the page ending. A wrong chunk counter or a size setting latched at the wrong time shows up as valid flags in the wrong slots. Stale flags are caught by sampling the slots one cycle after the first beat of a new page, before any chunk closes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int BIDX_W = 9;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;

  // Contribution of one byte at chunk offset bidx: {even half, odd half}.
  function automatic logic [CODE_W-1:0] byte_code(input logic [7:0] d,
                                                   input logic [BIDX_W-1:0] bidx);
    logic [HALF_W-1:0] odd_h;
    logic [HALF_W-1:0] even_h;
    logic              par;
    par    = ^d;
    odd_h  = '0;
    even_h = '0;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 8; i++) begin
        if (((i >> k) & 1) == 1) odd_h[k]  = odd_h[k] ^ d[i];
        else                     even_h[k] = even_h[k] ^ d[i];
      end
    end
    for (int k = 0; k < BIDX_W; k++) begin
      odd_h[k+3]  = par & bidx[k];
      even_h[k+3] = par & ~bidx[k];
    end
    return {even_h, odd_h};
  endfunction

  function automatic logic [2:0] chunks_for(input logic [1:0] sz);
    case (sz)
      2'd3:    return 3'd4;
      2'd2:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/nand_ecc_feed.sv
module nand_ecc_feed
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              s_valid,
  output logic              s_first,
  output logic              s_close,
  output logic              s_last,
  output logic [7:0]        s_data,
  output logic [BIDX_W-1:0] s_bidx,
  output logic [1:0]        s_chunk
);
  localparam int CNT_W = $clog2(CHUNK_BYTES);
  localparam logic [CNT_W-1:0] LAST_OFS = CNT_W'(CHUNK_BYTES - 1);

  logic             page_open;
  logic [CNT_W-1:0] byte_cnt;
  logic [1:0]       chunk_cnt;
  logic [2:0]       nch_q;
  logic [2:0]       nch_now;
  logic [1:0]       chunk_mask;
  logic             full;

  always_comb begin
    nch_now    = page_open ? nch_q : chunks_for(cfg_size);
    chunk_mask = 2'(nch_now - 3'd1);
    full       = (byte_cnt == LAST_OFS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_open <= 1'b0;
      byte_cnt  <= '0;
      chunk_cnt <= '0;
      nch_q     <= 3'd1;
      s_valid   <= 1'b0;
      s_first   <= 1'b0;
      s_close   <= 1'b0;
      s_last    <= 1'b0;
      s_data    <= '0;
      s_bidx    <= '0;
      s_chunk   <= '0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_data  <= in_data;
        s_bidx  <= BIDX_W'(byte_cnt);
        s_chunk <= chunk_cnt;
        s_first <= !page_open;
        s_close <= full | in_last;
        s_last  <= in_last;
        if (in_last) begin
          page_open <= 1'b0;
          byte_cnt  <= '0;
          chunk_cnt <= '0;
        end else begin
          page_open <= 1'b1;
          if (!page_open) nch_q <= nch_now;
          if (full) begin
            byte_cnt  <= '0;
            chunk_cnt <= (chunk_cnt + 2'd1) & chunk_mask;
          end else begin
            byte_cnt <= byte_cnt + CNT_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_first,
  input  logic              s_close,
  input  logic [7:0]        s_data,
  input  logic [BIDX_W-1:0] s_bidx,
  input  logic [1:0]        s_chunk,
  output logic [NUM_SLOTS-1:0] slot_valid,
  output logic [CODE_W-1:0] slot_code [NUM_SLOTS],
  output logic [CODE_W-1:0] acc_q
);
  logic [CODE_W-1:0] closing;

  always_comb closing = acc_q ^ byte_code(s_data, s_bidx);

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (s_valid) acc_q <= s_close ? '0 : closing;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_code[g]  <= '0;
        slot_valid[g] <= 1'b0;
      end else if (s_valid) begin
        if (s_close && (s_chunk == 2'(g))) begin
          slot_code[g]  <= closing;
          slot_valid[g] <= 1'b1;
        end else if (s_first) begin
          slot_valid[g] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_page_size,
  input  logic        beat_valid,
  input  logic [7:0]  beat_data,
  input  logic        beat_last,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_word,
  output logic        busy
);
  localparam int NUM_SLOTS = 4;

  logic              s_valid, s_first, s_close, s_last;
  logic [7:0]        s_data;
  logic [BIDX_W-1:0] s_bidx;
  logic [1:0]        s_chunk;
  logic [NUM_SLOTS-1:0] slot_valid;
  logic [CODE_W-1:0] slot_code [NUM_SLOTS];
  logic [CODE_W-1:0] acc_q;
  logic              chunk_done;

  nand_ecc_feed #(.CHUNK_BYTES(CHUNK_BYTES)) u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_size (cfg_page_size),
    .in_valid (beat_valid),
    .in_data  (beat_data),
    .in_last  (beat_last),
    .s_valid  (s_valid),
    .s_first  (s_first),
    .s_close  (s_close),
    .s_last   (s_last),
    .s_data   (s_data),
    .s_bidx   (s_bidx),
    .s_chunk  (s_chunk)
  );

  nand_ecc_accum #(.NUM_SLOTS(NUM_SLOTS)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_first    (s_first),
    .s_close    (s_close),
    .s_data     (s_data),
    .s_bidx     (s_bidx),
    .s_chunk    (s_chunk),
    .slot_valid (slot_valid),
    .slot_code  (slot_code),
    .acc_q      (acc_q)
  );

  always_comb begin
    chunk_done = s_valid & s_close;
    busy       = s_valid & s_last;
    rd_word    = {1'b0, slot_valid[rd_sel], 6'b0, slot_code[rd_sel]};
  end

endmodule

// File: rtl/nand_ecc_check.sv
module nand_ecc_check (
  input logic        clk,
  input logic        rst_n,
  input logic        beat_valid,
  input logic        beat_last,
  input logic        busy,
  input logic        chunk_done,
  input logic        s_valid,
  input logic        s_first,
  input logic        s_close,
  input logic [1:0]  s_chunk,
  input logic [3:0]  slot_valid,
  input logic [23:0] acc_q
);

  assert_busy_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last) |=> busy);

  assert_valid_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> slot_valid[$past(s_chunk)]);

  assert_valid_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_first && !s_close) |=> (slot_valid == 4'b0));

  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !chunk_done |=> ((slot_valid & ~$past(slot_valid)) == 4'b0));

  assert_fresh_chunk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> (acc_q == 24'b0));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(acc_q));

endmodule

bind nand_page_ecc nand_ecc_check u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .beat_valid (beat_valid),
  .beat_last  (beat_last),
  .busy       (busy),
  .chunk_done (chunk_done),
  .s_valid    (s_valid),
  .s_first    (s_first),
  .s_close    (s_close),
  .s_chunk    (s_chunk),
  .slot_valid (slot_valid),
  .acc_q      (acc_q)
);

// File: tb/test_nand_page_ecc.sv
module test_nand_page_ecc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_page_size;
  logic        beat_valid;
  logic [7:0]  beat_data;
  logic        beat_last;
  logic [1:0]  rd_sel;
  logic [31:0] rd_word;
  logic        busy;

  int n_run  = 0;
  int n_fail = 0;

  logic [7:0]  page_mem [2048];
  logic [23:0] exp_code [4];
  logic        exp_vld  [4];

  // {size[16:15], pattern[14:13], gaps[12], byte count[11:0]}
  localparam logic [16:0] VEC [6] = '{
    {2'd1, 2'd0, 1'b0, 12'd512},
    {2'd2, 2'd1, 1'b1, 12'd1024},
    {2'd3, 2'd2, 1'b0, 12'd2048},
    {2'd3, 2'd3, 1'b1, 12'd700},
    {2'd0, 2'd1, 1'b0, 12'd512},
    {2'd1, 2'd2, 1'b0, 12'd513}
  };

  always #4 clk = ~clk;

  nand_page_ecc i_nand_page_ecc (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_page_size (cfg_page_size),
    .beat_valid    (beat_valid),
    .beat_data     (beat_data),
    .beat_last     (beat_last),
    .rd_sel        (rd_sel),
    .rd_word       (rd_word),
    .busy          (busy)
  );

  function automatic logic [7:0] gen_byte(int pat, int idx);
    case (pat)
      0:       return 8'(idx * 7 + 3);
      1:       return 8'(idx ^ (idx >> 4) ^ 8'h5a);
      2:       return 8'((idx * 13) >> 2);
      default: return ((idx % 3) == 0) ? 8'hff : 8'h01;
    endcase
  endfunction

  // Code from the per-bit address rule of R2.
  function automatic logic [23:0] ref_code(int start, int len);
    logic [11:0] o = '0;
    logic [11:0] e = '0;
    for (int j = 0; j < len; j++) begin
      for (int i = 0; i < 8; i++) begin
        if (page_mem[start + j][i]) begin
          logic [11:0] a;
          a = 12'(j * 8 + i);
          for (int k = 0; k < 12; k++) begin
            if (a[k]) o[k] = ~o[k];
            else      e[k] = ~e[k];
          end
        end
      end
    end
    return {e, o};
  endfunction

  task automatic build_expect(int size, int n);
    int nch, chunk, st;
    nch   = (size == 3) ? 4 : (size == 2) ? 2 : 1;
    chunk = 0;
    st    = 0;
    for (int s = 0; s < 4; s++) begin exp_vld[s] = 1'b0; exp_code[s] = '0; end
    for (int j = 0; j < n; j++) begin
      if ((j - st) == 511 || j == n - 1) begin
        exp_code[chunk] = ref_code(st, j - st + 1);
        exp_vld[chunk]  = 1'b1;
        chunk = (chunk + 1) % nch;
        st    = j + 1;
      end
    end
  endtask

  task automatic check_eq(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive_beat(logic [7:0] d, logic last, logic [1:0] cfg);
    @(negedge clk);
    beat_valid    = 1'b1;
    beat_data     = d;
    beat_last     = last;
    cfg_page_size = cfg;
  endtask

  task automatic send_page(int size, int pat, bit gaps, int n);
    for (int j = 0; j < n; j++) page_mem[j] = gen_byte(pat, j);
    for (int j = 0; j < n; j++) begin
      if (gaps && (j % 5) == 2) begin
        // R9: idle cycle with misleading data and last flag
        @(negedge clk);
        beat_valid = 1'b0;
        beat_data  = 8'ha5;
        beat_last  = 1'b1;
      end
      // R8: size setting inverted after the first beat
      drive_beat(page_mem[j], j == n - 1, (j == 0) ? 2'(size) : ~2'(size));
    end
    @(negedge clk);
    beat_valid = 1'b0;
    beat_last  = 1'b0;
    check_eq("R5 busy after last beat", int'(busy), 1);
    @(negedge clk);
    check_eq("R5 busy drops", int'(busy), 0);
  endtask

  task automatic check_slots(string tag);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #1;
      check_eq({tag, " R6 valid bit"}, int'(rd_word[30]), int'(exp_vld[s]));
      check_eq({tag, " R4 status zero"}, int'({rd_word[31], rd_word[29:24]}), 0);
      if (exp_vld[s]) check_eq({tag, " R2 code"}, int'(rd_word[23:0]), int'(exp_code[s]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n         = 1'b0;
    cfg_page_size = 2'd1;
    beat_valid    = 1'b0;
    beat_data     = '0;
    beat_last     = 1'b0;
    rd_sel        = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 busy at reset", int'(busy), 0);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #1;
      check_eq("R1 slot at reset", int'(rd_word), 0);
    end

    // R3 size encodings, R7 partial chunk, R10 wrap past final chunk
    for (int v = 0; v < 6; v++) begin
      int size = int'(VEC[v][16:15]);
      int pat  = int'(VEC[v][14:13]);
      int n    = int'(VEC[v][11:0]);
      send_page(size, pat, VEC[v][12], n);
      build_expect(size, n);
      check_slots($sformatf("R3 vector %0d", v));
    end

    // R6: flags clear after the first beat of a new page
    page_mem[0] = 8'h3c;
    page_mem[1] = 8'hc3;
    drive_beat(page_mem[0], 1'b0, 2'd1);
    @(negedge clk);
    beat_valid = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #1;
      check_eq("R6 flags cleared on new page", int'(rd_word[30]), 0);
    end
    drive_beat(page_mem[1], 1'b1, 2'd1);
    @(negedge clk);
    beat_valid = 1'b0;
    beat_last  = 1'b0;
    @(negedge clk);
    build_expect(1, 2);
    check_slots("R7 two-byte page");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule